// File: doc/BRIEF.md
# Debug Trace Port Reset and Mode Controller

This block sits at the front of an on-chip debug trace port. It combines a power-on reset status, a system clock lock flag and a debug compliance enable pin into one asynchronous reset for the downstream debug logic. It holds a standard 16-state JTAG TAP controller, a small instruction register, and a port configuration register that is written and read back through the TAP. Two configuration bits choose the port mode: disabled, reduced or full. The mode sets the output enables of the auxiliary message data pins and the trace clock enable. After power-on, message data bit 0 carries the clock-locked status. It hands that bit back to the message stream once a configuration write turns the trace clock on.

All sequential logic runs on TCK. The TAP states are `TS_RESET` (Test-Logic-Reset), `TS_IDLE`, `TS_SEL_DR`, `TS_CAP_DR`, `TS_SHIFT_DR`, `TS_EXIT1_DR`, `TS_PAUSE_DR`, `TS_EXIT2_DR`, `TS_UPD_DR`, and the IR equivalents `TS_SEL_IR`, `TS_CAP_IR`, `TS_SHIFT_IR`, `TS_EXIT1_IR`, `TS_PAUSE_IR`, `TS_EXIT2_IR`, `TS_UPD_IR`. The transitions below follow the JTAG standard, written as state —TMS→ next state:
- RESET: 1 stays in RESET, 0 goes to IDLE.
- IDLE: 0 stays in IDLE, 1 goes to SEL_DR.
- SEL_DR: 1 goes to SEL_IR, 0 goes to CAP_DR.
- SEL_IR: 1 goes to RESET, 0 goes to CAP_IR.
- CAP: 0 goes to SHIFT, 1 goes to EXIT1.
- SHIFT: 0 stays in SHIFT, 1 goes to EXIT1.
- EXIT1: 1 goes to UPD, 0 goes to PAUSE.
- PAUSE: 0 stays in PAUSE, 1 goes to EXIT2.
- EXIT2: 1 goes to UPD, 0 goes back to SHIFT.
- UPD: 0 goes to IDLE, 1 goes to SEL_DR.

Top module: `dbgport_rst_mode`

## Requirements
- R1: `dbg_rst_o` is high, combinationally and with no TCK edge needed, whenever any of these holds: `por_i` is high, `comp_en_i` is low, the lock hold of R2 is active, or the TAP is in `TS_RESET`.
- R2: After `por_i` falls, `dbg_rst_o` stays high until `sys_lock_i` is seen high at a TCK rising edge. After that, a later drop of `sys_lock_i` does not reassert the reset. Only a new power-on reset clears this state.
- R3: Five consecutive TCK rising edges with TMS high bring the TAP to `TS_RESET` from any state.
- R4: While `dbg_rst_o` is high, `mdo_oe_o` is all zero, `trace_clk_en_o` is low and `port_mode_o` reads 2'b00. Under a hard reset (R5) every register is cleared at once. In `TS_RESET` the configuration register is cleared to zero, the lock display flag is set, and the instruction register is set to all ones at the next TCK edge.
- R5: TCK, TMS and TDI have no effect while `por_i` is high, `comp_en_i` is low, or the lock hold is active. A reset that comes only from `TS_RESET` still lets TMS move the TAP out of that state.
- R6: Configuration bit 0 is the trace-clock enable and bit 1 is the full-port select. `port_mode_o` is 2'b00 (disabled) whenever bit 0 is clear, whatever bit 1 holds. It is 2'b01 (reduced) for bit 0 = 1 and bit 1 = 0, and 2'b10 (full) when both bits are set.
- R7: In full mode, all `MDO_FULL` bits of `mdo_oe_o` are set and `trace_clk_en_o` is high.
- R8: In reduced mode, only the low `MDO_RED` bits of `mdo_oe_o` are set and `trace_clk_en_o` is high.
- R9: In disabled mode, `mdo_oe_o` is zero and `trace_clk_en_o` is low. The configuration register can still be written and read through the TAP.
- R10: `mdo_o[0]` shows `sys_lock_i` from reset until the first Update-DR of the configuration register with bit 0 set. From then until the next reset it carries `msg_data_i[0]`. The other `mdo_o` bits always pass `msg_data_i` through.
- R11: The instruction register is `IR_W` bits wide. It is loaded with all ones at reset, and Capture-IR loads it with 1 in bit 0 and zeros elsewhere. The opcode `CFG_OP` (4'hA by default) selects the `CFG_W`-bit configuration register. It shifts LSB first from TDI toward TDO, Capture-DR loads the current value, and Update-DR writes it. Any other opcode selects a 1-bit bypass register and leaves the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_i | input | 1 | Power-on reset status, high while active |
| sys_lock_i | input | 1 | System clock lock flag |
| comp_en_i | input | 1 | Debug compliance enable, high selects debug access |
| tck_i | input | 1 | TAP test clock |
| tms_i | input | 1 | TAP mode select |
| tdi_i | input | 1 | TAP serial data in |
| msg_data_i | input | MDO_FULL | Message data from the packetizer |
| tdo_o | output | 1 | TAP serial data out |
| dbg_rst_o | output | 1 | Asynchronous reset to downstream debug blocks, high active |
| mdo_oe_o | output | MDO_FULL | Output enables of the message data pins |
| mdo_o | output | MDO_FULL | Message data to the pins, bit 0 multiplexed with lock status |
| trace_clk_en_o | output | 1 | Trace clock output enable |
| port_mode_o | output | 2 | 00 disabled, 01 reduced, 10 full |

## Verification
The bench drives TAP traffic while the compliance pin is low. A design that does not block TCK/TMS/TDI in that case would come out of the sequence with a live port mode instead of the disabled one. The bench also lets the TAP leave Test-Logic-Reset while only the TAP state is holding the reset; a design that gated the TAP on the whole debug reset would deadlock there. Other checks target the full-port bit set with the trace-clock enable clear, the stickiness of the lock display, lock loss after lock was first seen, and a write under a bypass opcode. Each of these would show up as a wrong mode, wrong enables or a wrong bit 0. The five-ones escape is started from Shift-DR, so a TAP with a wrong escape path would still hold an active mode.

// File: rtl/dbgport_pkg.sv
package dbgport_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PM_OFF     = 2'b00,
        PM_REDUCED = 2'b01,
        PM_FULL    = 2'b10
    } port_mode_e;

    localparam int TCE_BIT  = 0;
    localparam int FULL_BIT = 1;

endpackage

// File: rtl/dbgport_tap_fsm.sv
module dbgport_tap_fsm
    import dbgport_pkg::*;
(
    input  logic       tck_i,
    input  logic       hard_rst_i,
    input  logic       tms_i,
    output tap_state_e state_o
);

    tap_state_e state_q, state_d;

    always_ff @(posedge tck_i or posedge hard_rst_i) begin
        if (hard_rst_i) state_q <= TS_RESET;
        else            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_RESET:    state_d = tms_i ? TS_RESET    : TS_IDLE;
            TS_IDLE:     state_d = tms_i ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_DR:   state_d = tms_i ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   state_d = tms_i ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: state_d = tms_i ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_EXIT1_DR: state_d = tms_i ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: state_d = tms_i ? TS_EXIT2_DR : TS_PAUSE_DR;
            TS_EXIT2_DR: state_d = tms_i ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   state_d = tms_i ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_IR:   state_d = tms_i ? TS_RESET    : TS_CAP_IR;
            TS_CAP_IR:   state_d = tms_i ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: state_d = tms_i ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_EXIT1_IR: state_d = tms_i ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: state_d = tms_i ? TS_EXIT2_IR : TS_PAUSE_IR;
            TS_EXIT2_IR: state_d = tms_i ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   state_d = tms_i ? TS_SEL_DR   : TS_IDLE;
        endcase
    end

    assign state_o = state_q;

    // Run length of TMS-high edges, used only by the escape check below.
    logic [2:0] ones_q;
    always_ff @(posedge tck_i or posedge hard_rst_i) begin
        if (hard_rst_i)            ones_q <= '0;
        else if (!tms_i)           ones_q <= '0;
        else if (ones_q != 3'd7)   ones_q <= ones_q + 3'd1;
    end

    AST_FIVE_ONES_ESCAPE: assert property (@(posedge tck_i) disable iff (hard_rst_i)
        (ones_q >= 3'd5) |-> (state_q == TS_RESET)); // R3

endmodule

// File: rtl/dbgport_regs.sv
module dbgport_regs
    import dbgport_pkg::*;
#(
    parameter int              IR_W   = 4,
    parameter int              CFG_W  = 8,
    parameter logic [IR_W-1:0] CFG_OP = 4'hA
) (
    input  logic             tck_i,
    input  logic             hard_rst_i,
    input  tap_state_e       state_i,
    input  logic             tdi_i,
    output logic             tdo_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic             lock_show_o
);

    logic [IR_W-1:0]  ir_q, ir_sh_q;
    logic [CFG_W-1:0] dr_sh_q, cfg_q;
    logic             lock_show_q;
    logic             sel_cfg;

    assign sel_cfg = (ir_q == CFG_OP);

    always_ff @(posedge tck_i or posedge hard_rst_i) begin
        if (hard_rst_i) begin
            ir_q        <= '1;
            ir_sh_q     <= '0;
            dr_sh_q     <= '0;
            cfg_q       <= '0;
            lock_show_q <= 1'b1;
        end else begin
            unique case (state_i)
                TS_RESET: begin
                    ir_q        <= '1;
                    cfg_q       <= '0;
                    lock_show_q <= 1'b1;
                end
                TS_CAP_IR: begin
                    ir_sh_q    <= '0;
                    ir_sh_q[0] <= 1'b1;
                end
                TS_SHIFT_IR: ir_sh_q <= {tdi_i, ir_sh_q[IR_W-1:1]};
                TS_UPD_IR:   ir_q    <= ir_sh_q;
                TS_CAP_DR:   dr_sh_q <= sel_cfg ? cfg_q : '0;
                TS_SHIFT_DR: begin
                    if (sel_cfg) dr_sh_q    <= {tdi_i, dr_sh_q[CFG_W-1:1]};
                    else         dr_sh_q[0] <= tdi_i;
                end
                TS_UPD_DR: begin
                    if (sel_cfg) begin
                        cfg_q <= dr_sh_q;
                        if (dr_sh_q[TCE_BIT]) lock_show_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign tdo_o       = (state_i == TS_SHIFT_IR) ? ir_sh_q[0] : dr_sh_q[0];
    assign cfg_o       = cfg_q;
    assign lock_show_o = lock_show_q;

    AST_BYPASS_KEEPS_CFG: assert property (@(posedge tck_i) disable iff (hard_rst_i)
        (!sel_cfg && state_i != TS_RESET) |=> $stable(cfg_q)); // R11
    AST_LOCK_SHOW_CLEARS_ON_TCE_WRITE: assert property (@(posedge tck_i) disable iff (hard_rst_i)
        $fell(lock_show_q) |-> $past(state_i == TS_UPD_DR && sel_cfg && dr_sh_q[TCE_BIT])); // R10

endmodule

// File: rtl/dbgport_pins.sv
module dbgport_pins
    import dbgport_pkg::*;
#(
    parameter int MDO_FULL = 12,
    parameter int MDO_RED  = 4
) (
    input  logic                tck_i,
    input  logic                rst_i,
    input  logic                tce_i,
    input  logic                full_i,
    input  logic                lock_show_i,
    input  logic                sys_lock_i,
    input  logic [MDO_FULL-1:0] msg_data_i,
    output logic [MDO_FULL-1:0] mdo_oe_o,
    output logic [MDO_FULL-1:0] mdo_o,
    output logic                trace_clk_en_o,
    output port_mode_e          mode_o
);

    logic [MDO_FULL-1:0] red_mask;

    for (genvar g = 0; g < MDO_FULL; g++) begin : g_red_mask
        assign red_mask[g] = (g < MDO_RED);
    end

    always_comb begin
        mode_o         = PM_OFF;
        mdo_oe_o       = '0;
        trace_clk_en_o = 1'b0;
        if (!rst_i && tce_i) begin
            trace_clk_en_o = 1'b1;
            if (full_i) begin
                mode_o   = PM_FULL;
                mdo_oe_o = '1;
            end else begin
                mode_o   = PM_REDUCED;
                mdo_oe_o = red_mask;
            end
        end
    end

    always_comb begin
        mdo_o    = msg_data_i;
        mdo_o[0] = lock_show_i ? sys_lock_i : msg_data_i[0];
    end

    AST_REDUCED_LOW_PINS_ONLY: assert property (@(posedge tck_i) disable iff (rst_i)
        (mode_o == PM_REDUCED) |-> ((mdo_oe_o & ~red_mask) == '0)); // R8

endmodule

// File: rtl/dbgport_rst_mode.sv
module dbgport_rst_mode
    import dbgport_pkg::*;
#(
    parameter int              MDO_FULL = 12,
    parameter int              MDO_RED  = 4,
    parameter int              IR_W     = 4,
    parameter int              CFG_W    = 8,
    parameter logic [IR_W-1:0] CFG_OP   = 4'hA
) (
    input  logic                por_i,
    input  logic                sys_lock_i,
    input  logic                comp_en_i,
    input  logic                tck_i,
    input  logic                tms_i,
    input  logic                tdi_i,
    input  logic [MDO_FULL-1:0] msg_data_i,
    output logic                tdo_o,
    output logic                dbg_rst_o,
    output logic [MDO_FULL-1:0] mdo_oe_o,
    output logic [MDO_FULL-1:0] mdo_o,
    output logic                trace_clk_en_o,
    output logic [1:0]          port_mode_o
);

    tap_state_e       tap_state;
    logic             lock_seen_q;
    logic             hard_rst;
    logic [CFG_W-1:0] cfg;
    logic             lock_show;
    port_mode_e       mode;

    always_ff @(posedge tck_i or posedge por_i) begin
        if (por_i)           lock_seen_q <= 1'b0;
        else if (sys_lock_i) lock_seen_q <= 1'b1;
    end

    assign hard_rst  = por_i | ~comp_en_i | ~lock_seen_q;
    assign dbg_rst_o = hard_rst | (tap_state == TS_RESET);

    dbgport_tap_fsm i_tap (
        .tck_i      (tck_i),
        .hard_rst_i (hard_rst),
        .tms_i      (tms_i),
        .state_o    (tap_state)
    );

    dbgport_regs #(.IR_W(IR_W), .CFG_W(CFG_W), .CFG_OP(CFG_OP)) i_regs (
        .tck_i       (tck_i),
        .hard_rst_i  (hard_rst),
        .state_i     (tap_state),
        .tdi_i       (tdi_i),
        .tdo_o       (tdo_o),
        .cfg_o       (cfg),
        .lock_show_o (lock_show)
    );

    dbgport_pins #(.MDO_FULL(MDO_FULL), .MDO_RED(MDO_RED)) i_pins (
        .tck_i          (tck_i),
        .rst_i          (dbg_rst_o),
        .tce_i          (cfg[TCE_BIT]),
        .full_i         (cfg[FULL_BIT]),
        .lock_show_i    (lock_show),
        .sys_lock_i     (sys_lock_i),
        .msg_data_i     (msg_data_i),
        .mdo_oe_o       (mdo_oe_o),
        .mdo_o          (mdo_o),
        .trace_clk_en_o (trace_clk_en_o),
        .mode_o         (mode)
    );

    assign port_mode_o = mode;

    AST_QUIET_IN_RESET: assert property (@(posedge tck_i) disable iff (por_i)
        dbg_rst_o |-> (mdo_oe_o == '0 && !trace_clk_en_o)); // R4
    AST_HELD_UNTIL_LOCK: assert property (@(posedge tck_i) disable iff (por_i)
        !lock_seen_q |-> (dbg_rst_o && tap_state == TS_RESET)); // R2

endmodule

// File: tb/test_dbgport_rst_mode.sv
module test_dbgport_rst_mode;

    localparam int MDO_FULL = 12;
    localparam int MDO_RED  = 4;
    localparam int IR_W     = 4;
    localparam int CFG_W    = 8;
    localparam logic [IR_W-1:0] CFG_OP = 4'hA;

    logic                por = 1'b1, lock = 1'b0, comp = 1'b0;
    logic                tck = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic [MDO_FULL-1:0] msg = 12'hA5C;
    logic                tdo, dbg_rst, tce_out;
    logic [MDO_FULL-1:0] oe, mdo;
    logic [1:0]          mode;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 tck = ~tck;

    dbgport_rst_mode #(.MDO_FULL(MDO_FULL), .MDO_RED(MDO_RED), .IR_W(IR_W),
                       .CFG_W(CFG_W), .CFG_OP(CFG_OP)) i_dbgport_rst_mode (
        .por_i(por), .sys_lock_i(lock), .comp_en_i(comp),
        .tck_i(tck), .tms_i(tms), .tdi_i(tdi), .msg_data_i(msg),
        .tdo_o(tdo), .dbg_rst_o(dbg_rst), .mdo_oe_o(oe), .mdo_o(mdo),
        .trace_clk_en_o(tce_out), .port_mode_o(mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d);
        @(negedge tck);
        tms = m;
        tdi = d;
        @(posedge tck);
        #1;
    endtask

    task automatic write_ir(input logic [IR_W-1:0] op);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < IR_W; i++) tick(i == IR_W - 1, op[i]);
        tick(1, 0); tick(0, 0);
    endtask

    task automatic write_dr(input logic [CFG_W-1:0] v);
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < CFG_W; i++) tick(i == CFG_W - 1, v[i]);
        tick(1, 0); tick(0, 0);
    endtask

    task automatic read_dr(output logic [CFG_W-1:0] v);
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < CFG_W; i++) begin
            v[i] = tdo;
            tick(i == CFG_W - 1, v[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic t_por_state;
        repeat (3) @(posedge tck);
        #1;
        chk("R1 rst during por", dbg_rst, 1);
        chk("R4 oe during por", oe, 0);
        chk("R4 trace clk during por", tce_out, 0);
        chk("R4 mode during por", mode, 0);
    endtask

    task automatic t_lock_hold;
        @(negedge tck);
        comp = 1'b1;
        por  = 1'b0;
        tick(0, 0); tick(0, 0); tick(0, 0);
        chk("R2 held until lock", dbg_rst, 1);
        chk("R10 bit0 shows lock low", mdo[0], 0);
        @(negedge tck);
        lock = 1'b1;
        tick(1, 0);
        chk("R1 tlr keeps reset", dbg_rst, 1);
        chk("R10 bit0 shows lock high", mdo[0], 1);
        tick(0, 0);
        chk("R5 tap leaves tlr", dbg_rst, 0);
    endtask

    task automatic t_noncompliant;
        @(negedge tck);
        comp = 1'b0;
        #1;
        chk("R1 async on comp low", dbg_rst, 1);
        write_ir(CFG_OP);
        write_dr(8'h03);
        @(negedge tck);
        comp = 1'b1;
        tick(0, 0);
        chk("R5 traffic ignored mode", mode, 0);
        chk("R5 traffic ignored oe", oe, 0);
        chk("R5 out of reset", dbg_rst, 0);
    endtask

    task automatic t_full;
        logic [CFG_W-1:0] rb;
        write_ir(CFG_OP);
        write_dr(8'hC3);
        chk("R7 full mode", mode, 2'b10);
        chk("R7 full oe", oe, 12'hFFF);
        chk("R7 trace clk", tce_out, 1);
        chk("R10 bit0 now msg", mdo[0], msg[0]);
        chk("R10 upper bits msg", mdo[MDO_FULL-1:1], msg[MDO_FULL-1:1]);
        read_dr(rb);
        chk("R11 readback", rb, 8'hC3);
        chk("R11 readback keeps cfg", mode, 2'b10);
    endtask

    task automatic t_reduced_disabled;
        logic [CFG_W-1:0] rb;
        write_dr(8'h01);
        chk("R8 reduced mode", mode, 2'b01);
        chk("R8 reduced oe", oe, 12'h00F);
        chk("R8 trace clk", tce_out, 1);
        write_dr(8'h02);
        chk("R6 full bit without tce", mode, 2'b00);
        chk("R9 disabled oe", oe, 0);
        chk("R9 disabled trace clk", tce_out, 0);
        chk("R10 lock display sticky off", mdo[0], msg[0]);
        read_dr(rb);
        chk("R9 access in disabled", rb, 8'h02);
    endtask

    task automatic t_bypass;
        logic [CFG_W-1:0] rb;
        write_ir(4'h3);
        write_dr(8'h03);
        chk("R11 bypass write ignored", mode, 2'b00);
        write_ir(CFG_OP);
        read_dr(rb);
        chk("R11 cfg unchanged by bypass", rb, 8'h02);
    endtask

    task automatic t_five_ones;
        write_dr(8'h03);
        tick(1, 0); tick(0, 0); tick(0, 0);
        chk("R7 full before escape", oe, 12'hFFF);
        repeat (5) tick(1, 0);
        chk("R3 five ones to tlr", dbg_rst, 1);
        chk("R4 oe off in tlr", oe, 0);
        tick(0, 0);
        chk("R4 cfg cleared by tlr", mode, 0);
        chk("R10 lock display restored", mdo[0], 1);
        @(negedge tck);
        lock = 1'b0;
        #1;
        chk("R2 lock loss no reset", dbg_rst, 0);
        chk("R10 bit0 follows lock", mdo[0], 0);
        @(negedge tck);
        por = 1'b1;
        #1;
        chk("R1 async on por", dbg_rst, 1);
    endtask

    initial begin
        t_por_state();
        t_lock_hold();
        t_noncompliant();
        t_full();
        t_reduced_disabled();
        t_bypass();
        t_five_ones();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule